// File: doc/BRIEF.md
# 64b/66b Transmit Gearbox

This block packs a stream of 66-bit line blocks into a gap-free stream of fixed-width words for a serializer. Each block is a 2-bit sync header followed by 64 payload bits. The user side supplies the payload one slice per clock, either 16 or 32 bits wide as set by the parameter `W`. On the clock that carries the first slice of a block, the user also supplies that block's header. The output is one `W`-bit word per clock. Output words cross block boundaries wherever the packing puts them.

Each block adds 2 bits beyond the payload width, so the output side runs ahead of the input side. Over 33 clocks the block takes 32 payload slices and emits 33 full words. A 6-bit sequence value names the current phase of that 33-clock period. At the last phase (32) the block raises a pause flag, and the user must hold its data for that clock. The sequence value comes from an internal counter, or in external mode from user logic, which drives it every clock.

Top module: `gbx66_tx`

## Requirements
- R1: While reset is asserted, `word_out`, `seq_out` and `in_pause` are all zero, and no leftover bits remain for after reset.
- R2: In internal mode, `seq_out` is 0 on the first clock after the internal reset is released. It then steps by one per clock through 0..32 and wraps from 32 to 0.
- R3: In external mode, `seq_out` equals `ext_seq` in the same clock. The value is taken as given, with no legality check.
- R4: `in_pause` is high exactly when the active sequence value is 32. In internal mode this happens once every 33 clocks.
- R5: `blk_hdr` and `blk_data` presented during a pause clock have no effect on the output bitstream.
- R6: `blk_hdr` is taken only when the active sequence value is a multiple of 64/W (a block start). At all other values it is ignored.
- R7: Bit order on the line: `word_out[W-1]` goes first. For each block, header bit 1 goes first, then header bit 0, then payload slices in sequence order, each slice from bit W-1 down to bit 0.
- R8: `word_out` updates one clock after the slice that feeds it is presented. The first word after reset starts with the first block's two header bits.
- R9: The concatenated output words equal the concatenation of all input blocks, with no gap or repeat, over any number of 33-clock periods.
- R10: With W=16, the word produced from the slice at sequence 4 is: the last 2 payload bits of block 0, then the 2 header bits of block 1, then the top 12 bits of block 1's first slice.
- R11: With W=32, the first word is the header plus the top 30 bits of the first slice. The word from sequence 2 is: 2 leftover payload bits, then the next header, then 28 payload bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| ext_seq_mode | input | 1 | 1: sequence value taken from `ext_seq`; 0: internal counter |
| ext_seq | input | 6 | Sequence value supplied by user logic in external mode |
| blk_hdr | input | 2 | Sync header of the block whose first slice is presented |
| blk_data | input | W | Payload slice, first-sent bit at W-1 |
| seq_out | output | 6 | Active sequence value for the current clock |
| in_pause | output | 1 | High on the clock in which input must be held |
| word_out | output | W | Packed output word, first-sent bit at W-1 |

## Verification
A wrong fill level or a wrong leftover register shows up in the very next output word as a bit slip. Once it appears, every later word until reset is shifted by the same amount. A sequence counter that steps wrongly shows up on `seq_out` and `in_pause` in the same clock. A misplaced pause or header phase surfaces within one word as extra or missing header bits. The bench reframes the output stream against the blocks it sent, in both widths and both modes, so any such slip is caught at the first affected word.

// File: rtl/gbx66_pkg.sv
package gbx66_pkg;
  localparam int HDR_W    = 2;
  localparam int PAY_W    = 64;
  // Each block adds HDR_W extra bits; after W/HDR_W blocks the spare equals one word.
  // (W/2) blocks * (64/W) slices = 32 slices per period, independent of W.
  localparam int SEQ_LAST = PAY_W / HDR_W;
  localparam int SEQ_W    = $clog2(SEQ_LAST + 1);

  function automatic int slices_per_blk(input int w);
    return PAY_W / w;
  endfunction
endpackage

// File: rtl/gbx_rst_sync.sv
module gbx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/gbx_seq.sv
module gbx_seq import gbx66_pkg::*; #(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_mode,
  input  logic [SEQ_W-1:0] ext_seq,
  output logic [SEQ_W-1:0] seq_act,
  output logic             pause,
  output logic             blk_start
);
  localparam int               SPB    = slices_per_blk(W);
  localparam logic [SEQ_W-1:0] SPB_M  = SEQ_W'(SPB - 1);
  localparam logic [SEQ_W-1:0] LAST_V = SEQ_W'(SEQ_LAST);

  logic [SEQ_W-1:0] cnt_q;
  logic [SEQ_W-1:0] cnt_d;

  always_comb begin
    seq_act   = ext_mode ? ext_seq : cnt_q;
    pause     = (seq_act == LAST_V);
    blk_start = !pause && ((seq_act & SPB_M) == '0);
    // counter follows the active value so a mode change keeps the phase
    if (seq_act >= LAST_V) cnt_d = '0;
    else                   cnt_d = seq_act + SEQ_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/gbx_pack.sv
module gbx_pack import gbx66_pkg::*; #(
  parameter int W = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               take,
  input  logic                               hdr_sel,
  input  logic [HDR_W-1:0]                   hdr,
  input  logic [W-1:0]                       data,
  output logic [W-1:0]                       word_q,
  output logic [$clog2(2*W+HDR_W+1)-1:0]     fill_q
);
  localparam int CW = 2*W + HDR_W;        // leftover plus newest bits
  localparam int NW = W + HDR_W;          // widest input contribution
  localparam int FW = $clog2(CW + 1);

  logic [W-1:0]  res_q, res_d, word_d;
  logic [FW-1:0] fill_d, nbits, total;
  logic [NW-1:0] nb;
  logic [CW-1:0] merged;

  always_comb begin
    nb    = '0;
    nbits = '0;
    if (take) begin
      if (hdr_sel) begin
        nb    = {hdr, data};
        nbits = FW'(NW);
      end else begin
        nb    = {data, {HDR_W{1'b0}}};
        nbits = FW'(W);
      end
    end
    // leftover sits left-aligned; new bits land right after it
    merged = {res_q, {NW{1'b0}}} | ({nb, {W{1'b0}}} >> fill_q);
    word_d = merged[CW-1 -: W];
    res_d  = merged[NW-1 -: W];
    total  = fill_q + nbits;
    fill_d = (total > FW'(W)) ? (total - FW'(W)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      res_q  <= '0;
      fill_q <= '0;
    end else begin
      word_q <= word_d;
      res_q  <= res_d;
      fill_q <= fill_d;
    end
  end
endmodule

// File: rtl/gbx66_tx.sv
module gbx66_tx import gbx66_pkg::*; #(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_seq_mode,
  input  logic [SEQ_W-1:0] ext_seq,
  input  logic [HDR_W-1:0] blk_hdr,
  input  logic [W-1:0]     blk_data,
  output logic [SEQ_W-1:0] seq_out,
  output logic             in_pause,
  output logic [W-1:0]     word_out
);
  localparam int FILL_W = $clog2(2*W + HDR_W + 1);

  logic              rst_s_n;
  logic              blk_start;
  logic [FILL_W-1:0] fill_lvl;

  gbx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  gbx_seq #(.W(W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .ext_mode  (ext_seq_mode),
    .ext_seq   (ext_seq),
    .seq_act   (seq_out),
    .pause     (in_pause),
    .blk_start (blk_start)
  );

  gbx_pack #(.W(W)) u_pack (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .take    (!in_pause),
    .hdr_sel (blk_start),
    .hdr     (blk_hdr),
    .data    (blk_data),
    .word_q  (word_out),
    .fill_q  (fill_lvl)
  );
endmodule

// File: rtl/gbx66_tx_chk.sv
module gbx66_tx_chk import gbx66_pkg::*; #(
  parameter int W  = 16,
  parameter int FW = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_mode,
  input logic [SEQ_W-1:0] ext_seq,
  input logic [SEQ_W-1:0] seq,
  input logic             pause,
  input logic [FW-1:0]    fill
);
  localparam logic [SEQ_W-1:0] LAST_V = SEQ_W'(SEQ_LAST);

  p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(W));

  p_fill_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill[0] == 1'b0);

  p_pause_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && !ext_mode) |=> (fill == '0));

  p_pause_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && !ext_mode) |=> (ext_mode || !pause));

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && seq != LAST_V) |=> (ext_mode || seq == $past(seq) + SEQ_W'(1)));

  p_seq_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && seq == LAST_V) |=> (ext_mode || seq == '0));

  p_ext_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |-> (seq == ext_seq));
endmodule

bind gbx66_tx gbx66_tx_chk #(.W(W), .FW(FILL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_s_n),
  .ext_mode (ext_seq_mode),
  .ext_seq  (ext_seq),
  .seq      (seq_out),
  .pause    (in_pause),
  .fill     (fill_lvl)
);

// File: tb/gbx66_tx_tb.sv
`timescale 1ns/1ps
module gbx66_tx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        ext_mode = 1'b0;
  logic [5:0]  ext_seq = '0;
  logic [1:0]  hdr = '0;
  logic [31:0] data = '0;
  logic [5:0]  seq16, seq32;
  logic        pause16, pause32;
  logic [15:0] word16;
  logic [31:0] word32;

  always #10 clk = ~clk;

  gbx66_tx #(.W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_seq_mode(ext_mode), .ext_seq(ext_seq),
    .blk_hdr(hdr), .blk_data(data[15:0]),
    .seq_out(seq16), .in_pause(pause16), .word_out(word16));

  gbx66_tx #(.W(32)) u_dut32 (
    .clk(clk), .rst_n(rst_n), .ext_seq_mode(ext_mode), .ext_seq(ext_seq),
    .blk_hdr(hdr), .blk_data(data),
    .seq_out(seq32), .in_pause(pause32), .word_out(word32));

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  bit q16[$];
  bit q32[$];
  logic [1:0]  hh [8];
  logic [31:0] hd [8];

  // stimulus vectors: {header, 32-bit slice}; W=16 uses the low half
  localparam logic [33:0] STIM [16] = '{
    34'h1_0123_4567, 34'h2_89AB_CDEF, 34'h1_F0E1_D2C3, 34'h2_B4A5_9687,
    34'h3_0000_0001, 34'h0_8000_0000, 34'h1_FFFF_FFFF, 34'h2_0000_0000,
    34'h1_5555_AAAA, 34'h2_AAAA_5555, 34'h2_1357_9BDF, 34'h1_2468_ACE0,
    34'h3_DEAD_0001, 34'h1_C0DE_F00D, 34'h2_7FFF_FFFE, 34'h0_3C3C_C3C3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic pop_cmp(input int w, input logic [31:0] act, input string req);
    logic [31:0] e;
    bit ok;
    e  = '0;
    ok = 1;
    for (int i = w - 1; i >= 0; i--) begin
      if (w == 16) begin
        if (q16.size() == 0) ok = 0; else e[i] = q16.pop_front();
      end else begin
        if (q32.size() == 0) ok = 0; else e[i] = q32.pop_front();
      end
    end
    if (!ok) begin
      n_tests++;
      n_fail++;
      $display("FAIL %s: got %h expected more queued bits (stream underrun)", req, act);
    end else begin
      chk(req, act, e);
    end
  endtask

  task automatic do_reset(input bit ext);
    rst_n    = 1'b0;
    ext_mode = ext;
    ext_seq  = '0;
    hdr      = 2'b11;
    data     = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 word16 in reset", {16'b0, word16}, 32'h0);
    chk("R1 word32 in reset", word32, 32'h0);
    chk("R1 seq16 in reset", {26'b0, seq16}, 32'h0);
    chk("R1 pause in reset", {30'b0, pause16, pause32}, 32'h0);
    q16.delete();
    q32.delete();
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
  endtask

  task automatic run(input bit ext, input int ncyc, input int run_id);
    do_reset(ext);
    for (int c = 0; c <= ncyc; c++) begin
      int e;
      int p;
      string r16;
      string r32;
      logic [33:0] v;
      e = c % 33;
      p = (c + 32) % 33;
      @(negedge clk);
      if (c > 0) begin
        r16 = (p == 32) ? "R5 R7 w16" : (((p % 4) != 0) ? "R6 R7 w16" : "R9 R7 w16");
        r32 = (p == 32) ? "R5 R7 w32" : (((p % 2) != 0) ? "R6 R7 w32" : "R9 R7 w32");
        pop_cmp(16, {16'b0, word16}, r16);
        pop_cmp(32, word32, r32);
        if (c == 1) begin
          chk("R8 first word16 header", {30'b0, word16[15:14]}, {30'b0, hh[0]});
          chk("R11 first word32", word32, {hh[0], hd[0][31:2]});
        end
        if (c == 3) chk("R11 w32 block boundary", word32, {hd[1][1:0], hh[2], hd[2][31:4]});
        if (c == 5) chk("R10 w16 block boundary", {16'b0, word16},
                        {16'b0, hd[3][1:0], hh[4], hd[4][15:4]});
      end
      if (ext) ext_seq = 6'(e);
      if (e == 32) begin
        hdr  = 2'b11 ^ 2'(c);
        data = 32'hDEAD_BEEF ^ 32'(c);
      end else begin
        v    = STIM[(c + 5 * run_id) % 16];
        hdr  = v[33:32];
        data = v[31:0] ^ (32'(c / 16) * 32'h9E37_79B9);
        if ((e % 4) == 0) begin q16.push_back(hdr[1]); q16.push_back(hdr[0]); end
        for (int i = 15; i >= 0; i--) q16.push_back(data[i]);
        if ((e % 2) == 0) begin q32.push_back(hdr[1]); q32.push_back(hdr[0]); end
        for (int i = 31; i >= 0; i--) q32.push_back(data[i]);
      end
      if (c < 8) begin
        hh[c] = hdr;
        hd[c] = data;
      end
      #1;
      chk(ext ? "R3 seq16 follows input" : "R2 seq16 count", {26'b0, seq16}, 32'(e));
      chk(ext ? "R3 seq32 follows input" : "R2 seq32 count", {26'b0, seq32}, 32'(e));
      chk("R4 pause flags", {30'b0, pause16, pause32}, (e == 32) ? 32'h3 : 32'h0);
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;
    run(1'b0, 99, 0);
    run(1'b1, 99, 1);
    run(1'b0, 66, 2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule